// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes one PWM waveform and places it on any chosen subset of four output pins, A to D. A pin that is not selected carries a general-purpose data bit from the port instead. A small write port holds the configuration: the steering mask, the timing of a mask change, the polarity of the two pin pairs and a per-pin output enable. A sticky flag records the start of each PWM period.

The timing of a mask change is selected with each control write. The new mask can take effect at the next clock, which may cut a pulse short. It can also be held pending until the next period-start strobe, so that every pulse on a pin is complete. Firmware uses the period flag to wait out one full PWM cycle before it sets the output enables. All pin outputs and the flag are registered.

Top module: `pwm_steer`

## Requirements
- R1: After reset the active mask steers only pin A, nothing is pending, both pairs are active-high, all output enables are 0, every pin reads 0 and the period flag is 0.
- R2: Pin outputs are registered. One clock after an edge, an enabled pin shows the PWM input (after its pair's polarity) if its mask bit is 1. If its mask bit is 0 it shows its port data bit. Mask bit i (bit 0 = A, bit 3 = D) belongs to pin i.
- R3: A write to address 0 with bit 4 (sync) at 0 loads mask bits [3:0] at that clock edge and discards any pending mask.
- R4: A write to address 0 with sync at 1 stores the mask as pending. The active mask is unchanged until a clock edge where period_start is 1, and that edge applies it. A write in the same cycle as period_start stays pending for the following period.
- R5: Several sync writes made before a period start leave only the last mask pending, and that mask is the one applied.
- R6: Bit 5 of a control write sets the A/C pair active-low, and bit 6 does the same for the B/D pair. Both take effect at once. Inversion applies only to the PWM source, never to port data.
- R7: A write to address 1 sets the per-pin output enables from bits [3:0]. A disabled pin outputs 0.
- R8: period_flag is set by period_start and stays set until a write to address 2 with bit 0 at 1. When the set and the clear happen in the same cycle, the set wins. A write to address 2 with bit 0 at 0 leaves the flag as it is.
- R9: Writes to address 3 change no output or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Raw PWM waveform |
| period_start | input | 1 | One-cycle strobe at the start of a PWM period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 enables, 2 flag clear |
| wr_data | input | NPINS+3 | Write data |
| port_data | input | NPINS | General-purpose data for pins that are not steered |
| pin_out | output | NPINS | Registered pin levels, bit 0 = A |
| period_flag | output | 1 | Sticky period-start flag |

## Verification
The bench builds the block with the default of four pins. That setting covers both polarity pairs, all sixteen mask values and the full 7-bit control word. Directed phases combine writes with period strobes in the same cycle and in neighbouring cycles, to exercise the pending and immediate paths and the set-over-clear rule of the flag. Random PWM and port data run alongside, so that every pin source and polarity meets both input levels.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_OE   = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_FLAG = 2'd2;
endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
  import pwm_steer_pkg::*;
#(
  parameter int NPINS = 4,
  localparam int DW = NPINS + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              period_start,
  output logic [NPINS-1:0]  active_mask,
  output logic [1:0]        pol_low,
  output logic [NPINS-1:0]  oe
);
  localparam int SYNC_BIT = NPINS;
  localparam int POL_LSB  = NPINS + 1;

  logic [NPINS-1:0] pend_mask;
  logic             pend_vld;
  logic             wr_ctrl, wr_oe, wr_sync;

  assign wr_ctrl = wr_en && (wr_addr == SEL_CTRL);
  assign wr_oe   = wr_en && (wr_addr == SEL_OE);
  assign wr_sync = wr_data[SYNC_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask <= NPINS'(1);
      pend_mask   <= '0;
      pend_vld    <= 1'b0;
      pol_low     <= 2'b00;
      oe          <= '0;
    end else begin
      if (period_start && pend_vld) begin
        active_mask <= pend_mask;
        pend_vld    <= 1'b0;
      end
      if (wr_ctrl) begin
        pol_low <= wr_data[POL_LSB +: 2];
        if (wr_sync) begin
          pend_mask <= wr_data[NPINS-1:0];
          pend_vld  <= 1'b1;
        end else begin
          active_mask <= wr_data[NPINS-1:0];
          pend_vld    <= 1'b0;
        end
      end
      if (wr_oe) oe <= wr_data[NPINS-1:0];
    end
  end

  // R3: an immediate write sets the mask on the next cycle
  a_r3_immediate: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wr_sync) |=> (active_mask == $past(wr_data[NPINS-1:0])));
  // R4: a pending mask lands at the period strobe
  a_r4_pending_applied: assert property (@(posedge clk) disable iff (rst)
    (period_start && pend_vld && !(wr_ctrl && !wr_sync)) |=> (active_mask == $past(pend_mask)));
  // R4: without a period strobe or an immediate write the mask holds
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (!period_start && !(wr_ctrl && !wr_sync)) |=> $stable(active_mask));
  // R7: the enables change only through their own address
  a_r7_oe_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_oe |=> $stable(oe));
endmodule

// File: rtl/pwm_steer_mux.sv
module pwm_steer_mux #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_in,
  input  logic [NPINS-1:0] port_data,
  input  logic [NPINS-1:0] active_mask,
  input  logic [1:0]       pol_low,
  input  logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] pin_q
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam int PAIR = g % 2;
    logic pwm_pol, src;
    assign pwm_pol = pwm_in ^ pol_low[PAIR];
    assign src     = active_mask[g] ? pwm_pol : port_data[g];

    always_ff @(posedge clk) begin
      if (rst) pin_q[g] <= 1'b0;
      else     pin_q[g] <= oe[g] ? src : 1'b0;
    end

    // R7: a pin disabled in the previous cycle shows idle 0
    a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
      !$past(oe[g]) |-> !pin_q[g]);
    // R6: an unsteered enabled pin copies port data with no inversion
    a_r6_port_plain: assert property (@(posedge clk) disable iff (rst)
      ($past(oe[g]) && !$past(active_mask[g])) |-> (pin_q[g] == $past(port_data[g])));
  end
endmodule

// File: rtl/pwm_steer_flag.sv
module pwm_steer_flag (
  input  logic clk,
  input  logic rst,
  input  logic period_start,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)               flag_q <= 1'b0;
    else if (period_start) flag_q <= 1'b1;
    else if (clr)          flag_q <= 1'b0;
  end

  // R8: a period strobe always leaves the flag set
  a_r8_set: assert property (@(posedge clk) disable iff (rst)
    period_start |=> flag_q);
  // R8: the flag holds without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R8: a lone clear drops it
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !period_start) |=> !flag_q);
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int NPINS = 4,
  localparam int DW = NPINS + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwm_in,
  input  logic              period_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NPINS-1:0]  port_data,
  output logic [NPINS-1:0]  pin_out,
  output logic              period_flag
);
  logic [NPINS-1:0] active_mask, oe;
  logic [1:0]       pol_low;
  logic             flag_clr;

  assign flag_clr = wr_en && (wr_addr == SEL_FLAG) && wr_data[0];

  pwm_steer_regs #(.NPINS(NPINS)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .period_start,
    .active_mask, .pol_low, .oe
  );

  pwm_steer_mux #(.NPINS(NPINS)) u_mux (
    .clk, .rst, .pwm_in, .port_data, .active_mask, .pol_low, .oe,
    .pin_q(pin_out)
  );

  pwm_steer_flag u_flag (
    .clk, .rst, .period_start, .clr(flag_clr), .flag_q(period_flag)
  );

  // R1: outputs are idle during and right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (pin_out == '0 && !period_flag));
endmodule

// File: tb/pwm_steer_bench.sv
`timescale 1ns/1ps
module pwm_steer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0, period_start = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [3:0] port_data = '0;
  logic [3:0] pin_out;
  logic       period_flag;

  int n_cmp = 0, n_bad = 0;
  string req = "R1";
  bit rnd = 1'b0;

  always #2 clk = ~clk;

  pwm_steer u_pwm_steer (
    .clk, .rst, .pwm_in, .period_start, .wr_en, .wr_addr, .wr_data,
    .port_data, .pin_out, .period_flag
  );

  // behavioural reference model
  int m_act, m_pend, m_pol, m_oe, m_flag, m_exp;
  bit m_pv;
  always @(posedge clk) begin
    if (rst) begin
      m_act = 1; m_pend = 0; m_pv = 0; m_pol = 0; m_oe = 0; m_flag = 0; m_exp = 0;
    end else begin
      int nxt;
      m_exp = 0;
      for (int i = 0; i < 4; i++) begin
        int v;
        if ((m_act >> i) & 1) v = int'(pwm_in) ^ ((m_pol >> (i % 2)) & 1);
        else v = int'(port_data[i]);
        if ((m_oe >> i) & 1) m_exp = m_exp | (v << i);
      end
      if (period_start) m_flag = 1;
      else if (wr_en && wr_addr == 2 && wr_data[0]) m_flag = 0;
      nxt = m_act;
      if (period_start && m_pv) begin nxt = m_pend; m_pv = 0; end
      if (wr_en && wr_addr == 0) begin
        m_pol = int'(wr_data[6:5]);
        if (wr_data[4]) begin m_pend = int'(wr_data[3:0]); m_pv = 1; end
        else begin nxt = int'(wr_data[3:0]); m_pv = 0; end
      end
      if (wr_en && wr_addr == 1) m_oe = int'(wr_data[3:0]);
      m_act = nxt;
    end
  end

  task automatic compare();
    n_cmp++;
    if (pin_out !== 4'(m_exp)) begin
      n_bad++;
      $display("FAIL %s pins actual=%b expected=%b", req, pin_out, 4'(m_exp));
    end
    n_cmp++;
    if (period_flag !== 1'(m_flag)) begin
      n_bad++;
      $display("FAIL %s flag actual=%b expected=%b", req, period_flag, 1'(m_flag));
    end
  endtask

  // one clock; random data drive while rnd is set; compare at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = 1'b0; period_start = 1'b0;
    if (rnd) begin
      pwm_in = 1'($urandom);
      port_data = 4'($urandom);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d, input bit ps = 0);
    wr_en = 1'b1; wr_addr = a; wr_data = d; period_start = ps;
    tick();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic strobe();
    period_start = 1'b1;
    tick();
  endtask

  initial begin
    // R1: reset state and default steering to pin A
    req = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst = 1'b0;
    run(2);
    wr(2'd1, 7'h0F);
    pwm_in = 1'b1; port_data = 4'b0000;
    run(3);
    rnd = 1'b1;
    run(8);
    // R2: steering A and C, then all pins, then none
    req = "R2";
    wr(2'd0, 7'h05); run(10);
    wr(2'd0, 7'h0F); run(10);
    wr(2'd0, 7'h00); run(10);
    // R3: immediate change, cancelling a pending mask
    req = "R3";
    wr(2'd0, 7'h1A); run(3);
    wr(2'd0, 7'h03); run(4);
    strobe(); run(4);
    // R4: pending mask waits for the period strobe
    req = "R4";
    wr(2'd0, 7'h1C); run(6);
    strobe(); run(4);
    wr(2'd0, 7'h16, 1'b1); run(5);
    strobe(); run(4);
    // R5: the last pending write wins
    req = "R5";
    wr(2'd0, 7'h11); wr(2'd0, 7'h12); wr(2'd0, 7'h18); run(3);
    strobe(); run(5);
    // R6: polarity of each pair, port data stays plain
    req = "R6";
    wr(2'd0, 7'h25); run(8);
    wr(2'd0, 7'h4A); run(8);
    wr(2'd0, 7'h6F); run(8);
    wr(2'd0, 7'h63); run(8);
    // R7: partial enables
    req = "R7";
    wr(2'd1, 7'h05); run(8);
    wr(2'd1, 7'h0A); run(8);
    wr(2'd1, 7'h00); run(4);
    wr(2'd1, 7'h0F); run(4);
    // R8: flag set, sticky, clear, set beats clear, no-op clear
    req = "R8";
    wr(2'd2, 7'h01); run(2);
    strobe(); run(5);
    wr(2'd2, 7'h00); run(2);
    wr(2'd2, 7'h01); run(2);
    wr(2'd2, 7'h01, 1'b1); run(2);
    wr(2'd2, 7'h01); run(2);
    // R9: address 3 is inert
    req = "R9";
    wr(2'd3, 7'h7F); run(4);
    wr(2'd3, 7'h10); strobe(); run(4);
    // mixed random traffic
    req = "R4";
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 4) == 0) begin
        wr_en = 1'b1; wr_addr = 2'($urandom); wr_data = 7'($urandom);
      end
      period_start = ($urandom_range(0, 9) == 0);
      tick();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule